// File: doc/BRIEF.md
# Multi-Line Transmit DMA Engine

This block moves outgoing bytes for a bank of serial lines from memory to the line transmitters. The host reaches one line at a time. A line-select field in the control register steers later register accesses to that line. For the selected line, the host writes a byte count and a start address, which is split over a low and a high word. Setting the go bit in the high address word starts the transfer. A single fetch engine serves all active lines in turn. It reads one byte at a time over a simple request/acknowledge memory port and hands each byte, tagged with its line number, to a ready/valid byte sink.

A transfer can end in three ways: it completes normally, a memory read returns an error, or the host aborts it through the line's abort bit. In every case the line posts one completion entry. The host drains the entries by reading the control register, whose high byte shows a valid flag, the line number and the fault and abort flags. After an abort, the host learns how far the transfer got by reading the low address word, which advances by one for each byte sent.

Top module: `mux_tx_dma`

## Requirements
- R1: After reset, no completion is pending, `irq`, `mem_req` and `tx_valid` are low, and the control register (offset 0) reads zero.
- R2: Register offsets are 0 control, 1 line control, 2 line control 2, 3 count, 4 address low, 5 address high. Control bits [3:0] select the line that offsets 1 to 5 reach, and bit 6 is the interrupt enable. A value written at offset 3 for one line reads back for that line only.
- R3: Writing offset 5 with bit 15 set starts a transfer when the line is idle and its abort bit is clear. Bits [5:0] of that write are address bits [21:16]. The line's bytes are fetched from consecutive addresses and presented on `tx_data` with `tx_line`, and the address-low word advances once per byte accepted.
- R4: Control read bits are: [15] completion valid, [14] fault, [13] aborted, [11:8] line number. A control read removes the reported entry. Pending entries are reported lowest line number first, and a read with none pending shows bit 15 clear.
- R5: A start with a zero count posts a normal completion on the next cycle and issues no memory request.
- R6: A memory acknowledge with `mem_err` high ends the line's transfer and posts a completion with the fault flag set.
- R7: Setting bit 0 of the line control register ends an active transfer of that line and posts a completion with the aborted flag. Address low then equals the start address plus the number of bytes accepted.
- R8: A go write while the line's abort bit is set is ignored. Address-high bit 15 reads back as the line's busy state and stays 0.
- R9: A line is served only while its receive enable (line control bit 1) and its transmit enable (line control 2 bit 0) are both set. Until then, a started transfer stays busy and fetches nothing.
- R10: Only one memory fetch or byte hand-off is in progress at a time, and active lines are served one byte each in round-robin order.
- R11: `irq` is high exactly when the interrupt enable is set and at least one completion is pending.
- R12: A new completion for a line that lands in the same cycle as the control read removing that line's entry leaves the entry pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hwr_en | input | 1 | Host register write strobe |
| hwr_addr | input | 3 | Host write register offset |
| hwr_data | input | 16 | Host write data |
| hrd_en | input | 1 | Host register read strobe (a control read removes an entry) |
| hrd_addr | input | 3 | Host read register offset |
| hrd_data | output | 16 | Host read data, combinational from `hrd_addr` |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory read request, held until acknowledge |
| mem_addr | output | 22 | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge |
| mem_data | input | 8 | Memory read byte |
| mem_err | input | 1 | Memory read failed, qualified by `mem_ack` |
| tx_valid | output | 1 | Byte valid toward the transmitters |
| tx_line | output | 4 | Line the byte belongs to |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
The host's draining read of the control register and the posting of a new completion can hit the same line's entry in the same cycle. The bench provokes this by first posting a zero-count completion on one line. It then issues, in a single cycle, a control read that removes that entry together with a new zero-count go write for the same line. The read must report the line, and a following read must report the same line again before the queue shows empty.

// File: rtl/mux_tx_dma.sv
module mux_tx_dma #(
  parameter int NLINES = 16,
  parameter int AW     = 22,
  parameter int LW     = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hwr_en,
  input  logic [2:0]    hwr_addr,
  input  logic [15:0]   hwr_data,
  input  logic          hrd_en,
  input  logic [2:0]    hrd_addr,
  output logic [15:0]   hrd_data,
  output logic          irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_data,
  input  logic          mem_err,
  output logic          tx_valid,
  output logic [LW-1:0] tx_line,
  output logic [7:0]    tx_data,
  input  logic          tx_ready
);
  localparam int HW = AW - 16;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} st_t;

  logic [LW-1:0] sel;
  logic          ie;
  logic [15:0]   cnt [NLINES];
  logic [AW-1:0] adr [NLINES];
  logic [NLINES-1:0] busy, abrt, rxen, txen, pend, pfault, pabort, elig;
  st_t           st;
  logic [LW-1:0] cur, rr, pick, head, idx;
  logic          found;
  logic [7:0]    tbyte;

  assign elig = busy & rxen & txen & ~abrt;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NLINES; k++) begin
      idx = LW'((int'(rr) + k) % NLINES);
      if (!found && elig[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    head = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend[i]) head = LW'(i);
  end

  wire any_pend = |pend;
  wire pop      = hrd_en && hrd_addr == 3'd0 && any_pend;
  wire go       = hwr_en && hwr_addr == 3'd5 && hwr_data[15] && !busy[sel] && !abrt[sel];
  wire engaged  = st != S_IDLE;

  assign irq      = ie && any_pend;
  assign mem_req  = st == S_FETCH;
  assign mem_addr = adr[cur];
  assign tx_valid = st == S_SEND && !abrt[cur];
  assign tx_line  = cur;
  assign tx_data  = tbyte;

  always_comb begin
    hrd_data = '0;
    case (hrd_addr)
      3'd0: begin
        hrd_data[15]        = any_pend;
        hrd_data[14]        = any_pend && pfault[head];
        hrd_data[13]        = any_pend && pabort[head];
        hrd_data[8 +: LW]   = any_pend ? head : '0;
        hrd_data[6]         = ie;
        hrd_data[LW-1:0]    = sel;
      end
      3'd1: hrd_data[1:0] = {rxen[sel], abrt[sel]};
      3'd2: hrd_data[0]   = txen[sel];
      3'd3: hrd_data      = cnt[sel];
      3'd4: hrd_data      = adr[sel][15:0];
      3'd5: begin
        hrd_data[HW-1:0] = adr[sel][AW-1:16];
        hrd_data[15]     = busy[sel];
      end
      default: hrd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0; ie <= 1'b0;
      busy <= '0; abrt <= '0; rxen <= '0; txen <= '0;
      pend <= '0; pfault <= '0; pabort <= '0;
      st <= S_IDLE; cur <= '0; rr <= '0; tbyte <= '0;
      for (int i = 0; i < NLINES; i++) begin
        cnt[i] <= '0;
        adr[i] <= '0;
      end
    end else begin
      if (pop) pend[head] <= 1'b0;

      if (hwr_en) begin
        case (hwr_addr)
          3'd0: begin sel <= hwr_data[LW-1:0]; ie <= hwr_data[6]; end
          3'd1: begin abrt[sel] <= hwr_data[0]; rxen[sel] <= hwr_data[1]; end
          3'd2: txen[sel] <= hwr_data[0];
          3'd3: if (!busy[sel]) cnt[sel] <= hwr_data;
          3'd4: if (!busy[sel]) adr[sel][15:0] <= hwr_data;
          3'd5: if (!busy[sel]) adr[sel][AW-1:16] <= hwr_data[HW-1:0];
          default: ;
        endcase
      end

      if (go) begin
        if (cnt[sel] == '0) begin
          pend[sel] <= 1'b1; pfault[sel] <= 1'b0; pabort[sel] <= 1'b0;
        end else begin
          busy[sel] <= 1'b1;
        end
      end

      for (int i = 0; i < NLINES; i++) begin
        if (busy[i] && abrt[i] && !(engaged && cur == LW'(i))) begin
          busy[i] <= 1'b0;
          pend[i] <= 1'b1; pfault[i] <= 1'b0; pabort[i] <= 1'b1;
        end
      end

      case (st)
        S_IDLE: if (|elig) begin
          cur <= pick;
          rr  <= pick;
          st  <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (abrt[cur] || mem_err) begin
            busy[cur] <= 1'b0;
            pend[cur] <= 1'b1;
            pfault[cur] <= !abrt[cur];
            pabort[cur] <= abrt[cur];
            st <= S_IDLE;
          end else begin
            tbyte <= mem_data;
            st <= S_SEND;
          end
        end
        S_SEND: begin
          if (abrt[cur]) begin
            busy[cur] <= 1'b0;
            pend[cur] <= 1'b1; pfault[cur] <= 1'b0; pabort[cur] <= 1'b1;
            st <= S_IDLE;
          end else if (tx_ready) begin
            adr[cur] <= adr[cur] + AW'(1);
            cnt[cur] <= cnt[cur] - 16'd1;
            if (cnt[cur] == 16'd1) begin
              busy[cur] <= 1'b0;
              pend[cur] <= 1'b1; pfault[cur] <= 1'b0; pabort[cur] <= 1'b0;
            end
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cnt[sel] == '0) |=> (pend[$past(sel)] && !busy[$past(sel)]));

  // R3
  adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (adr[$past(cur)] == $past(adr[cur]) + AW'(1)));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && abrt[cur]) |=> (pend[$past(cur)] && pabort[$past(cur)] && !busy[$past(cur)]));

  // R6
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !abrt[cur]) |=> (pend[$past(cur)] && pfault[$past(cur)]));

  // R10
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  // R9
  enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || tx_valid) |-> (busy[cur] && rxen[cur] && txen[cur]));
endmodule

// File: tb/mux_tx_dma_tb.sv
module mux_tx_dma_tb;
  logic        clk = 0, rst_n = 0;
  logic        hwr_en = 0, hrd_en = 0;
  logic [2:0]  hwr_addr = 0, hrd_addr = 0;
  logic [15:0] hwr_data = 0, hrd_data;
  logic        irq, mem_req, mem_ack = 0, mem_err = 0;
  logic [21:0] mem_addr;
  logic [7:0]  mem_data = 0, tx_data;
  logic        tx_valid, tx_ready;
  logic [3:0]  tx_line;

  int tests = 0, fails = 0, n_log = 0, quota = 1000, req_cyc = 0;
  logic [3:0] log_line [256];
  logic [7:0] log_data [256];
  bit done = 0;

  always #5 clk = ~clk;

  mux_tx_dma u_dut (
    .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hwr_addr(hwr_addr), .hwr_data(hwr_data),
    .hrd_en(hrd_en), .hrd_addr(hrd_addr), .hrd_data(hrd_data), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .mem_err(mem_err), .tx_valid(tx_valid), .tx_line(tx_line), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  assign tx_ready = n_log < quota;

  function automatic logic [7:0] mval(input logic [21:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (mem_req) req_cyc++;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      mem_ack  = 1;
      mem_data = mval(mem_addr);
      mem_err  = mem_addr[21:20] == 2'b11;
    end
  end

  always @(posedge clk) if (tx_valid && tx_ready) begin
    log_line[n_log[7:0]] <= tx_line;
    log_data[n_log[7:0]] <= tx_data;
    n_log <= n_log + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); hwr_en = 1; hwr_addr = a; hwr_data = d;
    @(negedge clk); hwr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); hrd_en = 1; hrd_addr = a; #1 v = hrd_data;
    @(negedge clk); hrd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string r);
    int k = 0;
    while (!irq && k < 300) begin @(negedge clk); k++; end
    chk(r, irq, 1);
  endtask

  task automatic line_on(input logic [3:0] l);
    wr(0, 16'h0040 | l); wr(1, 16'h0002); wr(2, 16'h0001);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 irq", irq, 0); chk("R1 mem_req", mem_req, 0); chk("R1 tx_valid", tx_valid, 0);
    rd(0, v); chk("R1 csr", v, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(0, 16'h0003); wr(3, 16'h1234);
    wr(0, 16'h0004); wr(3, 16'h0055);
    wr(0, 16'h0003); rd(3, v); chk("R2 count line3", v, 16'h1234);
    wr(0, 16'h0004); rd(3, v); chk("R2 count line4", v, 16'h0055);
  endtask

  task automatic t_basic;
    logic [15:0] v; int b = n_log;
    line_on(2); wr(3, 3); wr(4, 16'h0100); wr(5, 16'h8000);
    wait_irq("R3 completion");
    chk("R3 byte count", n_log - b, 3);
    for (int j = 0; j < 3; j++) begin
      chk("R3 line", log_line[b + j], 2);
      chk("R3 data", log_data[b + j], mval(22'h100 + 22'(j)));
    end
    rd(0, v); chk("R4 csr entry", v, 16'h8242);
    rd(0, v); chk("R4 drained", v, 16'h0042);
    rd(4, v); chk("R3 addr advanced", v, 16'h0103);
  endtask

  task automatic t_zero;
    logic [15:0] v; int r;
    wr(0, 16'h0047); wr(3, 0);
    r = req_cyc;
    wr(5, 16'h8000);
    chk("R11 irq on", irq, 1);
    wr(0, 16'h0007); chk("R11 irq masked", irq, 0);
    wr(0, 16'h0047); chk("R11 irq again", irq, 1);
    chk("R5 no fetch", req_cyc - r, 0);
    rd(0, v); chk("R5 csr", v, 16'h8747);
  endtask

  task automatic t_fault;
    logic [15:0] v; int b = n_log;
    line_on(1); wr(3, 2); wr(4, 0); wr(5, 16'h8030);
    wait_irq("R6 completion");
    rd(0, v); chk("R6 csr fault", v, 16'hC141);
    chk("R6 no bytes", n_log - b, 0);
    rd(5, v); chk("R6 not busy", v[15], 0);
  endtask

  task automatic t_abort;
    logic [15:0] v; int b = n_log;
    line_on(5); wr(3, 10); wr(4, 16'h0200);
    quota = n_log + 2;
    wr(5, 16'h8000);
    idle(30);
    chk("R7 bytes before abort", n_log - b, 2);
    chk("R7 data0", log_data[b], mval(22'h200));
    chk("R7 data1", log_data[b + 1], mval(22'h201));
    wr(1, 16'h0003);
    wait_irq("R7 completion");
    rd(0, v); chk("R7 csr aborted", v, 16'hA545);
    rd(4, v); chk("R7 progress", v, 16'h0202);
    quota = 1000;
    wr(3, 1); wr(5, 16'h8000); idle(5);
    rd(5, v); chk("R8 go ignored", v, 16'h0000);
    chk("R8 no completion", irq, 0);
    wr(1, 16'h0002); wr(5, 16'h8000);
    wait_irq("R8 restart");
    rd(0, v); chk("R8 restart csr", v, 16'h8545);
  endtask

  task automatic t_enable;
    logic [15:0] v; int r;
    wr(0, 16'h0049); wr(1, 16'h0002); wr(2, 0); wr(3, 1); wr(4, 16'h0400);
    r = req_cyc;
    wr(5, 16'h8000); idle(10);
    chk("R9 no fetch", req_cyc - r, 0);
    rd(5, v); chk("R9 still busy", v, 16'h8000);
    wr(2, 1);
    wait_irq("R9 served");
    rd(0, v); chk("R9 csr", v, 16'h8949);
  endtask

  task automatic t_rr;
    logic [15:0] v; int b = n_log, k = 0;
    quota = n_log;
    for (int l = 10; l <= 12; l++) begin
      line_on(4'(l)); wr(3, 2); wr(4, 16'(l * 16)); wr(5, 16'h8000);
    end
    quota = 1000;
    while (n_log < b + 6 && k < 200) begin @(negedge clk); k++; end
    for (int j = 0; j < 6; j++) chk("R10 order", log_line[b + j], 10 + (j % 3));
    chk("R10 second byte", log_data[b + 3], mval(22'(10 * 16 + 1)));
    idle(3);
    rd(0, v); chk("R4 lowest first", v, 16'h8A4C);
    rd(0, v); chk("R4 next", v, 16'h8B4C);
    rd(0, v); chk("R4 last", v, 16'h8C4C);
    rd(0, v); chk("R4 empty", v, 16'h004C);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    wr(0, 16'h0046); wr(3, 0); wr(5, 16'h8000);
    @(negedge clk);
    hwr_en = 1; hwr_addr = 5; hwr_data = 16'h8000;
    hrd_en = 1; hrd_addr = 0; #1 v = hrd_data;
    @(negedge clk); hwr_en = 0; hrd_en = 0;
    chk("R12 read shows line6", v, 16'h8646);
    rd(0, v); chk("R12 entry kept", v, 16'h8646);
    rd(0, v); chk("R12 then empty", v, 16'h0046);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_regs; t_basic; t_zero; t_fault;
    t_abort; t_enable; t_rr; t_collide;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule